// File: doc/BRIEF.md
# PCM Time-Slot Serial Transmitter

This block places one 8-bit companded voice sample per frame onto a time-division serial highway. A parallel sample arrives from the encoder at any point in a frame and waits in a holding register. At the start of the next frame it is copied into the transmit word, which is then shifted out one bit at a time, sign bit first. The output side has three signals: a data bit, a drive enable that controls the tri-state pad, and an active-low slot strobe that can enable an external bus buffer.

There are two framing modes. In fixed-rate mode the master serial clock also clocks the data. A frame-sync pulse marks the slot, and a frame-sync pulse two clock periods long marks a signaling frame. In that frame, when mu-law coding is selected, the last bit of the word is replaced by the signaling bit. In variable-rate mode a separate data clock shifts the bits, and the frame-sync pin acts as a time-slot enable. For as long as that enable stays high, the same word is sent again in each further slot. A transmit-enable input from the standby sequencer can hold the pad in high impedance and the strobe high at any time.

The serial clocks and the frame-sync pin are level inputs sampled by the system clock `clk`. Each registered output reacts one `clk` cycle after the first sample that shows a serial-clock edge.

Top module: `pcm_slot_tx`

## Requirements
- R1: While `rst_n` is low and just after it is released, `pcm_drive` is 0 and `slot_n` is 1.
- R2: A word goes out on eight consecutive rising edges of the active serial clock, in this order: bit 7 (sign) first, then bit 6, down to bit 0 last. Each bit appears one `clk` cycle after the rising level is first sampled and holds until the next rising edge.
- R3: In fixed-rate mode (`var_mode`=0), the first bit goes out at the first `mclk` rising edge that samples `fs_en` high after an `mclk` rising edge that sampled it low. The next seven `mclk` rising edges carry the remaining bits. `dclk` is ignored.
- R4: In fixed-rate mode, `slot_n` goes low together with bit 1 and returns high at the `mclk` falling edge that ends bit 8.
- R5: `pcm_drive` is 0 outside a slot. It drops at the falling edge of the active serial clock that ends bit 8.
- R6: In variable-rate mode (`var_mode`=1), while `fs_en` is high the word goes out on the next eight `dclk` rising edges, `mclk` is ignored, and `slot_n` stays high.
- R7: In variable-rate mode, if `fs_en` is still high at the next `dclk` rising edge after a word completes, the same word is sent again, for any number of slots.
- R8: In variable-rate mode, `fs_en` going low ends the slot. `pcm_drive` is 0 one `clk` cycle later, even in the middle of a word.
- R9: A sample written with `smp_valid` is sent in the next frame that starts after the write. A write during a slot does not change the word being sent. A frame that had no new write sends the previous sample again.
- R10: In fixed-rate mode with `mu_law`=1, if `fs_en` is still high at the second `mclk` rising edge of the slot, bit 8 carries `sig_bit` instead of bit 0 of the word.
- R11: The signaling substitution never happens with `mu_law`=0, and never in variable-rate mode. In those cases bit 8 is bit 0 of the word.
- R12: While `tx_en` is 0, `pcm_drive` is 0 and `slot_n` is 1 whatever the framing. The slot sequencing continues internally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Active-low asynchronous reset |
| var_mode | input | 1 | 0: fixed-rate framing, 1: variable-rate framing |
| mu_law | input | 1 | 1: mu-law coding (signaling allowed), 0: A-law |
| tx_en | input | 1 | Output enable from the standby sequencer |
| mclk | input | 1 | Master serial clock level (data clock in fixed-rate mode) |
| dclk | input | 1 | Data clock level for variable-rate mode |
| fs_en | input | 1 | Frame sync (fixed-rate) or time-slot enable (variable-rate) |
| smp_valid | input | 1 | One-cycle strobe that writes `smp_data` to the holding register |
| smp_data | input | 8 | Companded sample, bit 7 is the sign |
| sig_bit | input | 1 | Signaling bit placed in bit 8 of a signaling frame |
| pcm_dat | output | 1 | Serial data bit, 0 while not driven |
| pcm_drive | output | 1 | Tri-state enable for the data pad, 1 means driven |
| slot_n | output | 1 | Active-low slot strobe for an external buffer |

## Verification
The assertions assume that `mclk`, `dclk` and `fs_en` are synchronous to `clk` and that every serial-clock half period lasts at least one `clk` cycle, so that each rising and each falling edge is seen once. They also assume that `var_mode` and `mu_law` change only while no slot is in progress, and that `fs_en` changes only while the active serial clock is low. The stimulus keeps within these limits: each serial half period is two `clk` cycles, modes are switched only between frames, and `fs_en` is moved only in a low half period or, for the abort case, only after the rising edge has been sampled. The fixed-rate sweep covers all 256 word values and alternates single and double frame-sync pulses.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  // Rising and falling event pair for a sampled serial clock.
  typedef struct packed {
    logic rise;
    logic fall;
  } edges_t;

  // Bit position pos (1 = first on the line) of a width-bit word sent MSB first.
  function automatic logic serial_bit(input logic [31:0] w,
                                      input int unsigned width,
                                      input int unsigned pos);
    logic [31:0] shifted;
    shifted = w >> (width - pos);
    return shifted[0];
  endfunction

  // Last bit of the slot: signaling bit replaces the LSB in a signaling frame.
  function automatic logic tail_bit(input logic lsb, input logic sig_on,
                                    input logic sig_val);
    return sig_on ? sig_val : lsb;
  endfunction

endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
  parameter int N = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          lvl,
  output pcm_tx_pkg::edges_t    evt [N]
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign evt[g].rise = lvl[g] & ~lvl_q[g];
    assign evt[g].fall = ~lvl[g] & lvl_q[g];
  end

endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             var_mode,
  input  logic             mu_law,
  input  logic             mclk_rise,
  input  logic             fs_lvl,
  input  logic             fs_rise,
  input  logic [CNT_W-1:0] bitcnt,
  output logic             start_evt,
  output logic             load_evt,
  output logic             sig_frame
);
  logic fs_at_rise_q;
  logic idle;
  logic sig_set;

  assign idle      = (bitcnt == '0);
  assign start_evt = !var_mode && mclk_rise && fs_lvl && !fs_at_rise_q && idle;
  assign load_evt  = var_mode ? fs_rise : start_evt;
  assign sig_set   = !var_mode && mu_law && mclk_rise && fs_lvl &&
                     (bitcnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_at_rise_q <= 1'b0;
      sig_frame    <= 1'b0;
    end else begin
      if (mclk_rise) fs_at_rise_q <= fs_lvl;
      if (start_evt)    sig_frame <= 1'b0;
      else if (sig_set) sig_frame <= 1'b1;
    end
  end

  // R10
  sig_only_fixed_mulaw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_frame) |-> $past(!var_mode && mu_law && fs_lvl));

  // R3
  start_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> fs_at_rise_q);

endmodule

// File: rtl/pcm_word_hold.sv
module pcm_word_hold #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_data,
  input  logic              load_evt,
  output logic [WORD_W-1:0] tx_word
);
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] word_q;

  // A frame start uses the hold contents from before any same-cycle write.
  assign tx_word = load_evt ? hold_q : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      word_q <= '0;
    end else begin
      if (smp_valid) hold_q <= smp_data;
      if (load_evt)  word_q <= hold_q;
    end
  end

endmodule

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              var_mode,
  input  edges_t            sclk,
  input  logic              fs_lvl,
  input  logic              start_evt,
  input  logic [WORD_W-1:0] word,
  input  logic              sig_frame,
  input  logic              sig_bit,
  output logic              dat_q,
  output logic              drive_q,
  output logic              slot_q,
  output logic [CNT_W-1:0]  bitcnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W);

  logic             begin_ok;
  logic [CNT_W-1:0] next_pos;
  logic             next_bit;

  assign begin_ok = var_mode ? 1'b1 : start_evt;
  assign next_pos = bitcnt + CNT_W'(1);

  always_comb begin
    if (next_pos == LAST)
      next_bit = tail_bit(word[0], sig_frame && !var_mode, sig_bit);
    else
      next_bit = serial_bit(32'(word), WORD_W, 32'(next_pos));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt  <= '0;
      drive_q <= 1'b0;
      slot_q  <= 1'b1;
      dat_q   <= 1'b0;
    end else if (var_mode && !fs_lvl) begin
      bitcnt  <= '0;
      drive_q <= 1'b0;
      slot_q  <= 1'b1;
    end else if (sclk.rise) begin
      if (bitcnt == '0) begin
        if (begin_ok) begin
          bitcnt  <= CNT_W'(1);
          drive_q <= 1'b1;
          slot_q  <= var_mode;
          dat_q   <= next_bit;
        end
      end else if (bitcnt < LAST) begin
        bitcnt <= next_pos;
        dat_q  <= next_bit;
      end
    end else if (sclk.fall && bitcnt == LAST) begin
      bitcnt  <= '0;
      drive_q <= 1'b0;
      slot_q  <= 1'b1;
    end
  end

  // R2
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= LAST);

  // R2
  advance_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt != $past(bitcnt) && bitcnt != '0) |-> $past(sclk.rise));

  // R2
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q && $past(drive_q) && !$past(sclk.rise)) |-> $stable(dat_q));

  // R4
  strobe_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_q |-> (drive_q && !var_mode));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_q) |-> ($past(sclk.fall) || $past(var_mode && !fs_lvl)));

  // R9
  word_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt != '0 && $past(bitcnt) != '0) |-> $stable(word));

endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              var_mode,
  input  logic              mu_law,
  input  logic              tx_en,
  input  logic              mclk,
  input  logic              dclk,
  input  logic              fs_en,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_data,
  input  logic              sig_bit,
  output logic              pcm_dat,
  output logic              pcm_drive,
  output logic              slot_n
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int IDX_MCLK = 0;
  localparam int IDX_DCLK = 1;
  localparam int IDX_FS   = 2;

  edges_t           evt [3];
  edges_t           sclk;
  logic             start_evt;
  logic             load_evt;
  logic             sig_frame;
  logic [CNT_W-1:0] bitcnt;
  logic [WORD_W-1:0] tx_word;
  logic             dat_q;
  logic             drive_q;
  logic             slot_q;

  pcm_edge_det #(.N(3)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({fs_en, dclk, mclk}),
    .evt   (evt)
  );

  assign sclk = var_mode ? evt[IDX_DCLK] : evt[IDX_MCLK];

  pcm_frame_ctl #(.CNT_W(CNT_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .var_mode  (var_mode),
    .mu_law    (mu_law),
    .mclk_rise (evt[IDX_MCLK].rise),
    .fs_lvl    (fs_en),
    .fs_rise   (evt[IDX_FS].rise),
    .bitcnt    (bitcnt),
    .start_evt (start_evt),
    .load_evt  (load_evt),
    .sig_frame (sig_frame)
  );

  pcm_word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .load_evt  (load_evt),
    .tx_word   (tx_word)
  );

  pcm_slot_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .var_mode  (var_mode),
    .sclk      (sclk),
    .fs_lvl    (fs_en),
    .start_evt (start_evt),
    .word      (tx_word),
    .sig_frame (sig_frame),
    .sig_bit   (sig_bit),
    .dat_q     (dat_q),
    .drive_q   (drive_q),
    .slot_q    (slot_q),
    .bitcnt    (bitcnt)
  );

  // R12: the standby gate acts on the pads only, sequencing runs on.
  assign pcm_drive = drive_q & tx_en;
  assign slot_n    = slot_q | ~tx_en;
  assign pcm_dat   = pcm_drive & dat_q;

  // R6
  var_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (var_mode && $past(var_mode)) |-> slot_n);

endmodule

// File: tb/tb_pcm_slot_tx.sv
module tb_pcm_slot_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       var_mode = 1'b0;
  logic       mu_law = 1'b1;
  logic       tx_en = 1'b1;
  logic       mclk = 1'b0;
  logic       dclk = 1'b0;
  logic       fs_en = 1'b0;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = 8'h00;
  logic       sig_bit = 1'b0;
  logic       pcm_dat;
  logic       pcm_drive;
  logic       slot_n;

  int checks = 0;
  int failures = 0;
  logic s_dat, s_drv, s_slot;

  always #4 clk = ~clk;

  pcm_slot_tx dut (
    .clk(clk), .rst_n(rst_n), .var_mode(var_mode), .mu_law(mu_law),
    .tx_en(tx_en), .mclk(mclk), .dclk(dclk), .fs_en(fs_en),
    .smp_valid(smp_valid), .smp_data(smp_data), .sig_bit(sig_bit),
    .pcm_dat(pcm_dat), .pcm_drive(pcm_drive), .slot_n(slot_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int want_bit(input int w, input int pos);
    return (w / (1 << (8 - pos))) % 2;
  endfunction

  // One half period of the active serial clock, two system clocks long.
  task automatic half(input logic level);
    if (var_mode) dclk = level; else mclk = level;
    @(negedge clk);
    s_dat = pcm_dat; s_drv = pcm_drive; s_slot = slot_n;
    @(negedge clk);
  endtask

  task automatic load(input int v);
    @(negedge clk); smp_valid = 1'b1; smp_data = 8'(v);
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic fixed_frame(input int w, input bit dbl, input bit sigv,
                             input bit exp_sig, input bit vis,
                             input bit mid_do, input int mid_val);
    int exp_b;
    sig_bit = sigv;
    fs_en = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      half(1'b1);
      chk(vis ? "R5 drive in slot" : "R12 drive gated", s_drv, vis);
      chk(vis ? "R4 strobe low" : "R12 strobe gated", s_slot, !vis);
      exp_b = (i == 8 && exp_sig) ? int'(sigv) : want_bit(w, i);
      if (vis) chk(i == 8 ? "R10/R11 bit8" : "R3 fixed bit", s_dat, exp_b);
      half(1'b0);
      chk("R5 release at bit8 fall", s_drv, vis && i < 8);
      chk("R4 strobe return", s_slot, !(vis && i < 8));
      if ((i == 1 && !dbl) || (i == 2 && dbl)) fs_en = 1'b0;
      if (mid_do && i == 4) load(mid_val);
    end
    for (int k = 0; k < 2; k++) begin
      half(1'b1);
      chk("R5 idle hi-z", s_drv, 0);
      chk("R4 idle strobe", s_slot, 1);
      half(1'b0);
    end
  endtask

  task automatic var_slots(input int w, input int nrep, input bit sigv);
    sig_bit = sigv;
    fs_en = 1'b1;
    @(negedge clk);
    for (int r = 0; r < nrep; r++) begin
      for (int i = 1; i <= 8; i++) begin
        half(1'b1);
        chk(r == 0 ? "R6 var drive" : "R7 repeat drive", s_drv, 1);
        chk("R6 var strobe high", s_slot, 1);
        chk(r == 0 ? (i == 8 ? "R11 var bit8" : "R6 var bit") : "R7 repeat bit",
            s_dat, want_bit(w, i));
        half(1'b0);
        chk("R5 var release", s_drv, i < 8);
      end
    end
    fs_en = 1'b0;
    @(negedge clk);
    half(1'b1);
    chk("R8 no slot when disabled", s_drv, 0);
    half(1'b0);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset drive", pcm_drive, 0);
    chk("R1 reset strobe", slot_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset drive", pcm_drive, 0);
    chk("R1 post-reset strobe", slot_n, 1);

    // Fixed-rate sweep over all words, alternating single/double sync (R2, R3, R10).
    for (int v = 0; v < 256; v++) begin
      load(v);
      fixed_frame(v, v % 2 == 0, (v % 4) < 2, v % 2 == 0, 1'b1, 1'b0, 0);
    end
    // R9: no new write, previous word repeats.
    fixed_frame(255, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    // R9: a mid-slot write does not disturb the current word, appears next frame.
    load(8'h3C);
    fixed_frame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3);
    fixed_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    // R11: A-law double sync, no substitution (LSB of 0xC3 is 1, sig 0).
    mu_law = 1'b0;
    fixed_frame(8'hC3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    mu_law = 1'b1;
    // R12: gated frame, then sequencing still sends the next frame normally.
    tx_en = 1'b0;
    load(8'h81);
    fixed_frame(8'h81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    tx_en = 1'b1;
    fixed_frame(8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);

    // Variable-rate mode.
    var_mode = 1'b1;
    load(8'h96);
    var_slots(8'h96, 3, 1'b1);
    load(8'h5B);
    var_slots(8'h5B, 1, 1'b0);
    // R3/R6: master clock pulses ignored in variable-rate mode.
    fs_en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); mclk = 1'b1; @(negedge clk);
      chk("R6 mclk ignored", pcm_drive, 0);
      mclk = 1'b0;
    end
    // R8: enable dropped mid-word.
    for (int i = 1; i <= 3; i++) begin
      half(1'b1);
      chk("R8 pre-abort bit", s_dat, want_bit(8'h5B, i));
      half(1'b0);
    end
    half(1'b1);
    fs_en = 1'b0;
    @(negedge clk);
    chk("R8 abort release", pcm_drive, 0);
    half(1'b0);
    // R3: data clock ignored in fixed-rate mode.
    var_mode = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); dclk = 1'b1; @(negedge clk);
      chk("R3 dclk ignored", pcm_drive, 0);
      dclk = 1'b0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule